// File: doc/BRIEF.md
# Prefetch Request Queue

This block sits between a prefetch address generator and a memory request port. When a demand miss is accepted, the block first cleans its queue. It drops any queued entry for the missed block. When squashing is enabled, it also drops the speculative entries at the young end of the queue that are not yet due. It then latches up to `DEGREE` candidate block addresses, each with its own delay. Over the following `DEGREE` cycles it inserts them, one per cycle.

Each candidate is checked before it is inserted. It is dropped if the outstanding miss queue already holds its block, or if the queue already holds it. Depending on a mode pin, it is also dropped if the cache already holds it. Surviving candidates go in at the young end of the queue. If the queue is full, the oldest entry is thrown away first. Entries leave from the old end through a valid/ready handshake, once the system time has reached their ready time.

The cache tag lookup and the miss-queue lookup are external and answer in the same cycle. Six event counters record what happened to candidates and entries.

Top module: `pf_req_queue`

## Requirements
- R1: Every address compared, stored or driven out has its low log2(`BLK_BYTES`) bits forced to zero; with the default 64-byte block, `pf_addr_o`, `cq_addr_o` and `mq_addr_o` always have bits [5:0] clear.
- R2: An accepted miss whose block equals a queued entry removes that entry, and `cnt_mrem_o` rises by one.
- R3: With `cfg_serial_squash_i` high, an accepted miss at time T removes entries from the young end while the youngest remaining entry has ready time >= T. It stops at the first entry that is due earlier. Each removal adds one to `cnt_squash_o`. With the pin low, nothing is squashed.
- R4: A valid candidate is dropped if `mq_hit_i` is high for its block. Otherwise it is dropped if a queued entry already holds its block, and that case adds one to `cnt_dup_o`. The queue never holds two entries for one block.
- R5: A miss with `miss_uncache_i` high has no effect. With `cfg_data_only_i` high, a miss with `miss_ifetch_i` high also has no effect.
- R6: With `cfg_cache_at_push_i` high, a candidate whose block hits in the cache (`cq_hit_i`) is not inserted. With it low, candidates skip the cache check. Instead, a due head entry that hits in the cache is popped without being offered on `pf_valid_o`.
- R7: Inserting into a full queue of `DEPTH` entries discards the oldest entry first, and `cnt_evict_o` rises by one. The new entry is then placed at the young end.
- R8: An entry's ready time is the miss time plus that candidate's delay, modulo 2^`TW`. Only the oldest entry is offered, and only once `now_i` >= its ready time.
- R9: The head leaves the queue when `pf_valid_o` and `pf_ready_i` are both high, and `cnt_issue_o` rises by one. While `pf_ready_i` is low, the head stays.
- R10: `bus_req_o` is high exactly while the queue holds at least one entry.
- R11: A miss with at least one valid candidate makes `busy_o` high for exactly `DEGREE` cycles, starting the cycle after it is accepted. While `busy_o` is high, misses are ignored and nothing is offered. In a cycle where a miss is accepted, nothing is offered.
- R12: `cnt_ident_o` counts every valid candidate slot when it is processed, whatever the filtering outcome.
- R13: After reset the queue is empty, `busy_o` is low, and all counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now_i | input | TW | System time used for ready times and squashing |
| cfg_cache_at_push_i | input | 1 | 1: cache check at insertion; 0: cache check at issue |
| cfg_serial_squash_i | input | 1 | Enables squashing of young entries on a miss |
| cfg_data_only_i | input | 1 | Ignore instruction-fetch misses |
| miss_valid_i | input | 1 | Demand miss present |
| miss_addr_i | input | AW | Miss byte address |
| miss_uncache_i | input | 1 | Miss is to an uncacheable address |
| miss_ifetch_i | input | 1 | Miss is an instruction fetch |
| cand_valid_i | input | DEGREE | Per-slot candidate valid |
| cand_addr_i | input | DEGREE*AW | Candidate addresses, slot k at [k*AW +: AW] |
| cand_delay_i | input | DEGREE*DW | Candidate delays, slot k at [k*DW +: DW] |
| busy_o | output | 1 | Candidate insertion in progress |
| cq_addr_o | output | AW | Block address for the cache lookup |
| cq_hit_i | input | 1 | Cache lookup result |
| mq_addr_o | output | AW | Block address for the miss-queue lookup |
| mq_hit_i | input | 1 | Miss-queue lookup result |
| pf_valid_o | output | 1 | Prefetch request offered |
| pf_addr_o | output | AW | Prefetch block address |
| pf_ready_i | input | 1 | Memory port accepts the request |
| bus_req_o | output | 1 | Queue non-empty |
| cnt_ident_o | output | CW | Candidates seen |
| cnt_dup_o | output | CW | Candidates dropped as already queued |
| cnt_evict_o | output | CW | Entries discarded because the queue was full |
| cnt_mrem_o | output | CW | Entries removed by a matching miss |
| cnt_squash_o | output | CW | Entries squashed by a newer miss |
| cnt_issue_o | output | CW | Prefetches handed to the memory port |

## Verification
Random misses and candidates are drawn from a small pool of 24 blocks, so that matches, duplicates and lookup hits are frequent. This separates the miss-removal, duplicate and miss-queue filter paths. The run is split into windows where the memory port rarely accepts and windows where it usually does. The first kind fills the queue, so full-queue eviction and deep squashes can be told apart from ordinary oldest-first issue. All eight combinations of the three mode pins are swept. Directed sequences show that ignored misses leave a due entry untouched, and that at-issue cache hits drain the queue without issuing.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int PFQ_NUM_EV = 6;

    typedef enum int {
        EV_IDENT  = 0,
        EV_DUP    = 1,
        EV_EVICT  = 2,
        EV_MREM   = 3,
        EV_SQUASH = 4,
        EV_ISSUE  = 5
    } pfq_ev_e;

endpackage

// File: rtl/pfq_cam.sv
module pfq_cam #(
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0][AW-1:0] addr_i,
    input  logic [DEPTH-1:0]         valid_i,
    input  logic [AW-1:0]            key_i,
    output logic [DEPTH-1:0]         hit_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_o[g] = valid_i[g] && (addr_i[g] == key_i);
    end
endmodule

// File: rtl/pfq_tail_squash.sv
module pfq_tail_squash #(
    parameter int TW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                     en_i,
    input  logic [DEPTH-1:0]         live_i,
    input  logic [DEPTH-1:0][TW-1:0] rdy_i,
    input  logic [TW-1:0]            now_i,
    output logic [DEPTH-1:0]         kill_o
);
    always_comb begin
        logic halted;
        halted = 1'b0;
        kill_o = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (en_i && live_i[i] && !halted) begin
                if (rdy_i[i] >= now_i) kill_o[i] = 1'b1;
                else                   halted    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pfq_compact.sv
module pfq_compact #(
    parameter int AW    = 32,
    parameter int TW    = 16,
    parameter int DEPTH = 8,
    parameter int NW    = 4
) (
    input  logic [DEPTH-1:0][AW-1:0] addr_i,
    input  logic [DEPTH-1:0][TW-1:0] rdy_i,
    input  logic [DEPTH-1:0]         keep_i,
    output logic [DEPTH-1:0][AW-1:0] addr_o,
    output logic [DEPTH-1:0][TW-1:0] rdy_o,
    output logic [NW-1:0]            cnt_o
);
    always_comb begin
        int n;
        n      = 0;
        addr_o = '0;
        rdy_o  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep_i[i]) begin
                addr_o[n] = addr_i[i];
                rdy_o[n]  = rdy_i[i];
                n         = n + 1;
            end
        end
        cnt_o = NW'(n);
    end
endmodule

// File: rtl/pf_req_queue.sv
module pf_req_queue
    import pfq_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TW        = 16,
    parameter int DW        = 8,
    parameter int DEPTH     = 8,
    parameter int DEGREE    = 3,
    parameter int BLK_BYTES = 64,
    parameter int CW        = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        now_i,
    input  logic                 cfg_cache_at_push_i,
    input  logic                 cfg_serial_squash_i,
    input  logic                 cfg_data_only_i,
    input  logic                 miss_valid_i,
    input  logic [AW-1:0]        miss_addr_i,
    input  logic                 miss_uncache_i,
    input  logic                 miss_ifetch_i,
    input  logic [DEGREE-1:0]    cand_valid_i,
    input  logic [DEGREE*AW-1:0] cand_addr_i,
    input  logic [DEGREE*DW-1:0] cand_delay_i,
    output logic                 busy_o,
    output logic [AW-1:0]        cq_addr_o,
    input  logic                 cq_hit_i,
    output logic [AW-1:0]        mq_addr_o,
    input  logic                 mq_hit_i,
    output logic                 pf_valid_o,
    output logic [AW-1:0]        pf_addr_o,
    input  logic                 pf_ready_i,
    output logic                 bus_req_o,
    output logic [CW-1:0]        cnt_ident_o,
    output logic [CW-1:0]        cnt_dup_o,
    output logic [CW-1:0]        cnt_evict_o,
    output logic [CW-1:0]        cnt_mrem_o,
    output logic [CW-1:0]        cnt_squash_o,
    output logic [CW-1:0]        cnt_issue_o
);
    localparam int NW  = $clog2(DEPTH + 1);
    localparam int AIW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IW  = (DEGREE > 1) ? $clog2(DEGREE) : 1;
    localparam logic [AW-1:0] BLK_MASK = ~(AW'(BLK_BYTES) - AW'(1));

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0]      addr;
        logic [DEPTH-1:0][TW-1:0]      rdy;
        logic [NW-1:0]                 cnt;
        logic                          busy;
        logic [IW-1:0]                 idx;
        logic [DEGREE-1:0]             cv;
        logic [DEGREE-1:0][AW-1:0]     ca;
        logic [DEGREE-1:0][DW-1:0]     cd;
        logic [TW-1:0]                 mtime;
        logic [PFQ_NUM_EV-1:0][CW-1:0] ev;
    } state_t;

    state_t st_q, st_d;

    logic [DEPTH-1:0]              valid;
    logic [DEPTH-1:0]              miss_hit, cand_hit, kill, keep;
    logic [DEPTH-1:0][AW-1:0]      c_addr;
    logic [DEPTH-1:0][TW-1:0]      c_rdy;
    logic [NW-1:0]                 c_cnt;
    logic [AW-1:0]                 miss_blk, cand_blk;
    logic                          miss_take, head_elig, head_cached, push;
    logic [PFQ_NUM_EV-1:0][NW-1:0] inc;
    logic [TW-1:0]                 head_rdy;
    logic [NW-1:0]                 q_cnt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_valid
        assign valid[g] = (st_q.cnt > NW'(g));
    end

    assign miss_blk    = miss_addr_i & BLK_MASK;
    assign cand_blk    = st_q.ca[st_q.idx];
    assign miss_take   = miss_valid_i && !st_q.busy && !miss_uncache_i
                         && !(cfg_data_only_i && miss_ifetch_i);
    assign head_elig   = !miss_take && !st_q.busy && valid[0]
                         && (now_i >= st_q.rdy[0]);
    assign head_cached = !cfg_cache_at_push_i && cq_hit_i;

    assign pf_valid_o = head_elig && !head_cached;
    assign pf_addr_o  = st_q.addr[0];
    assign cq_addr_o  = st_q.busy ? cand_blk : st_q.addr[0];
    assign mq_addr_o  = cand_blk;
    assign bus_req_o  = valid[0];
    assign busy_o     = st_q.busy;
    assign head_rdy   = st_q.rdy[0];
    assign q_cnt      = st_q.cnt;

    assign cnt_ident_o  = st_q.ev[int'(EV_IDENT)];
    assign cnt_dup_o    = st_q.ev[int'(EV_DUP)];
    assign cnt_evict_o  = st_q.ev[int'(EV_EVICT)];
    assign cnt_mrem_o   = st_q.ev[int'(EV_MREM)];
    assign cnt_squash_o = st_q.ev[int'(EV_SQUASH)];
    assign cnt_issue_o  = st_q.ev[int'(EV_ISSUE)];

    pfq_cam #(.AW(AW), .DEPTH(DEPTH)) u_cam_miss (
        .addr_i (st_q.addr),
        .valid_i(valid),
        .key_i  (miss_blk),
        .hit_o  (miss_hit)
    );

    pfq_cam #(.AW(AW), .DEPTH(DEPTH)) u_cam_cand (
        .addr_i (st_q.addr),
        .valid_i(valid),
        .key_i  (cand_blk),
        .hit_o  (cand_hit)
    );

    pfq_tail_squash #(.TW(TW), .DEPTH(DEPTH)) u_squash (
        .en_i  (cfg_serial_squash_i),
        .live_i(valid & ~miss_hit),
        .rdy_i (st_q.rdy),
        .now_i (now_i),
        .kill_o(kill)
    );

    pfq_compact #(.AW(AW), .TW(TW), .DEPTH(DEPTH), .NW(NW)) u_compact (
        .addr_i(st_q.addr),
        .rdy_i (st_q.rdy),
        .keep_i(keep),
        .addr_o(c_addr),
        .rdy_o (c_rdy),
        .cnt_o (c_cnt)
    );

    // Operation decode: at most one of miss, insert, issue per cycle.
    always_comb begin
        keep = valid;
        push = 1'b0;
        inc  = '0;
        if (miss_take) begin
            keep                    = valid & ~miss_hit & ~kill;
            inc[int'(EV_MREM)]      = NW'(|miss_hit);
            inc[int'(EV_SQUASH)]    = NW'($countones(kill));
        end else if (st_q.busy) begin
            if (st_q.cv[st_q.idx]) begin
                inc[int'(EV_IDENT)] = NW'(1);
                if (cfg_cache_at_push_i && cq_hit_i) begin
                    push = 1'b0;
                end else if (mq_hit_i) begin
                    push = 1'b0;
                end else if (|cand_hit) begin
                    inc[int'(EV_DUP)] = NW'(1);
                end else begin
                    push = 1'b1;
                    if (valid[DEPTH-1]) begin
                        keep[0]             = 1'b0;
                        inc[int'(EV_EVICT)] = NW'(1);
                    end
                end
            end
        end else if (head_elig) begin
            if (head_cached) begin
                keep[0] = 1'b0;
            end else if (pf_ready_i) begin
                keep[0]             = 1'b0;
                inc[int'(EV_ISSUE)] = NW'(1);
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.addr = c_addr;
        st_d.rdy  = c_rdy;
        st_d.cnt  = c_cnt;
        if (push) begin
            st_d.addr[c_cnt[AIW-1:0]] = cand_blk;
            st_d.rdy[c_cnt[AIW-1:0]]  = st_q.mtime + TW'(st_q.cd[st_q.idx]);
            st_d.cnt                  = c_cnt + NW'(1);
        end
        if (miss_take) begin
            st_d.busy  = |cand_valid_i;
            st_d.idx   = '0;
            st_d.cv    = cand_valid_i;
            st_d.mtime = now_i;
            for (int k = 0; k < DEGREE; k++) begin
                st_d.ca[k] = cand_addr_i[k*AW +: AW] & BLK_MASK;
                st_d.cd[k] = cand_delay_i[k*DW +: DW];
            end
        end else if (st_q.busy) begin
            if (st_q.idx == IW'(DEGREE - 1)) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
            end
        end
        for (int e = 0; e < PFQ_NUM_EV; e++) begin
            st_d.ev[e] = st_q.ev[e] + CW'(inc[e]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pf_req_queue_chk.sv
module pf_req_queue_chk #(
    parameter int AW        = 32,
    parameter int TW        = 16,
    parameter int DEPTH     = 8,
    parameter int BLK_BYTES = 64,
    parameter int CW        = 16,
    parameter int NW        = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] now,
    input logic          pf_valid,
    input logic          pf_ready,
    input logic [AW-1:0] pf_addr,
    input logic          bus_req,
    input logic          busy,
    input logic          sq_en,
    input logic          miss_valid,
    input logic          miss_uncache,
    input logic [TW-1:0] head_rdy,
    input logic [NW-1:0] q_cnt,
    input logic [CW-1:0] cnt_issue,
    input logic [CW-1:0] cnt_squash,
    input logic [CW-1:0] cnt_mrem
);
    localparam int OFF = $clog2(BLK_BYTES);

    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFF-1:0] == '0));

    assert_bus_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> bus_req);

    assert_ready_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (now >= head_rdy));

    assert_issue_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> (cnt_issue == $past(cnt_issue) + CW'(1)));

    assert_busy_no_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pf_valid);

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q_cnt <= NW'(DEPTH));

    assert_squash_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_en |=> $stable(cnt_squash));

    assert_uncache_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_uncache) |=> $stable(cnt_mrem));
endmodule

bind pf_req_queue pf_req_queue_chk #(
    .AW(AW), .TW(TW), .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .CW(CW), .NW(NW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .now         (now_i),
    .pf_valid    (pf_valid_o),
    .pf_ready    (pf_ready_i),
    .pf_addr     (pf_addr_o),
    .bus_req     (bus_req_o),
    .busy        (busy_o),
    .sq_en       (cfg_serial_squash_i),
    .miss_valid  (miss_valid_i),
    .miss_uncache(miss_uncache_i),
    .head_rdy    (head_rdy),
    .q_cnt       (q_cnt),
    .cnt_issue   (cnt_issue_o),
    .cnt_squash  (cnt_squash_o),
    .cnt_mrem    (cnt_mrem_o)
);

// File: tb/pf_req_queue_tb.sv
module pf_req_queue_tb;
    localparam int AW = 32, TW = 16, DW = 8, DEPTH = 8, DEGREE = 3, BLK = 64, CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [TW-1:0]        now_i = '0;
    logic                 cap_i = 1'b1, sq_i = 1'b0, do_i = 1'b0;
    logic                 miss_valid = 1'b0, miss_unc = 1'b0, miss_if = 1'b0;
    logic [AW-1:0]        miss_addr = '0;
    logic [DEGREE-1:0]    cand_valid = '0;
    logic [DEGREE*AW-1:0] cand_addr = '0;
    logic [DEGREE*DW-1:0] cand_delay = '0;
    logic                 busy, pf_valid, bus_req, pf_ready = 1'b0;
    logic                 cq_hit, mq_hit;
    logic [AW-1:0]        cq_addr, mq_addr, pf_addr;
    logic [CW-1:0]        c_id, c_dup, c_ev, c_mr, c_sq, c_is;

    function automatic bit in_cache(input logic [AW-1:0] a);
        return (int'(a[AW-1:6]) % 7) == 3;
    endfunction
    function automatic bit in_mq(input logic [AW-1:0] a);
        return (int'(a[AW-1:6]) % 5) == 1;
    endfunction
    function automatic logic [AW-1:0] blk(input logic [AW-1:0] a);
        return a & ~AW'(BLK - 1);
    endfunction

    assign cq_hit = in_cache(cq_addr);
    assign mq_hit = in_mq(mq_addr);

    pf_req_queue #(.AW(AW), .TW(TW), .DW(DW), .DEPTH(DEPTH), .DEGREE(DEGREE),
                   .BLK_BYTES(BLK), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .now_i(now_i),
        .cfg_cache_at_push_i(cap_i), .cfg_serial_squash_i(sq_i), .cfg_data_only_i(do_i),
        .miss_valid_i(miss_valid), .miss_addr_i(miss_addr),
        .miss_uncache_i(miss_unc), .miss_ifetch_i(miss_if),
        .cand_valid_i(cand_valid), .cand_addr_i(cand_addr), .cand_delay_i(cand_delay),
        .busy_o(busy), .cq_addr_o(cq_addr), .cq_hit_i(cq_hit),
        .mq_addr_o(mq_addr), .mq_hit_i(mq_hit),
        .pf_valid_o(pf_valid), .pf_addr_o(pf_addr), .pf_ready_i(pf_ready),
        .bus_req_o(bus_req),
        .cnt_ident_o(c_id), .cnt_dup_o(c_dup), .cnt_evict_o(c_ev),
        .cnt_mrem_o(c_mr), .cnt_squash_o(c_sq), .cnt_issue_o(c_is)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // stimulus for the next cycle
    bit            s_miss, s_unc, s_if, s_rdy, s_cap = 1'b1, s_sq, s_do;
    logic [AW-1:0] s_maddr;
    logic [2:0]    s_cv;
    logic [AW-1:0] s_ca [DEGREE];
    logic [DW-1:0] s_cd [DEGREE];

    // reference model
    int            m_cnt = 0;
    logic [AW-1:0] m_a [DEPTH];
    logic [TW-1:0] m_r [DEPTH];
    bit            m_busy = 1'b0;
    int            m_idx = 0;
    logic [2:0]    m_cv;
    logic [AW-1:0] m_ca [DEGREE];
    logic [DW-1:0] m_cd [DEGREE];
    logic [TW-1:0] m_t;
    int e_id = 0, e_dup = 0, e_ev = 0, e_mr = 0, e_sq = 0, e_is = 0;
    logic [TW-1:0] tnow = '0;

    task automatic m_remove(input int p);
        for (int i = p; i < m_cnt - 1; i++) begin
            m_a[i] = m_a[i+1];
            m_r[i] = m_r[i+1];
        end
        m_cnt--;
    endtask

    function automatic bit m_take();
        return s_miss && !m_busy && !s_unc && !(s_do && s_if);
    endfunction

    task automatic model_step();
        if (m_take()) begin
            for (int i = 0; i < m_cnt; i++) begin
                if (m_a[i] == blk(s_maddr)) begin
                    m_remove(i);
                    e_mr++;
                    break;
                end
            end
            if (s_sq) begin
                while (m_cnt > 0 && m_r[m_cnt-1] >= tnow) begin
                    m_cnt--;
                    e_sq++;
                end
            end
            m_cv = s_cv;
            for (int k = 0; k < DEGREE; k++) begin
                m_ca[k] = blk(s_ca[k]);
                m_cd[k] = s_cd[k];
            end
            m_busy = (s_cv != 0);
            m_idx  = 0;
            m_t    = tnow;
        end else if (m_busy) begin
            if (m_cv[m_idx]) begin
                logic [AW-1:0] a;
                bit dup;
                a = m_ca[m_idx];
                e_id++;
                dup = 1'b0;
                for (int i = 0; i < m_cnt; i++) if (m_a[i] == a) dup = 1'b1;
                if (!(s_cap && in_cache(a)) && !in_mq(a)) begin
                    if (dup) e_dup++;
                    else begin
                        if (m_cnt == DEPTH) begin
                            m_remove(0);
                            e_ev++;
                        end
                        m_a[m_cnt] = a;
                        m_r[m_cnt] = m_t + TW'(m_cd[m_idx]);
                        m_cnt++;
                    end
                end
            end
            m_idx++;
            if (m_idx == DEGREE) begin
                m_busy = 1'b0;
                m_idx  = 0;
            end
        end else if (m_cnt > 0 && tnow >= m_r[0]) begin
            if (!s_cap && in_cache(m_a[0])) m_remove(0);
            else if (s_rdy) begin
                m_remove(0);
                e_is++;
            end
        end
    endtask

    task automatic tick();
        bit ev;
        @(negedge clk);
        now_i = tnow;
        cap_i = s_cap; sq_i = s_sq; do_i = s_do;
        miss_valid = s_miss; miss_addr = s_maddr; miss_unc = s_unc; miss_if = s_if;
        cand_valid = s_cv;
        for (int k = 0; k < DEGREE; k++) begin
            cand_addr[k*AW +: AW]  = s_ca[k];
            cand_delay[k*DW +: DW] = s_cd[k];
        end
        pf_ready = s_rdy;
        #2;
        ev = !m_take() && !m_busy && m_cnt > 0 && tnow >= m_r[0]
             && !(!s_cap && in_cache(m_a[0]));
        chk("R8 pf_valid", 32'(pf_valid), 32'(ev));
        if (ev) chk("R8 pf_addr oldest", pf_addr, m_a[0]);
        chk("R1 cq_addr aligned", cq_addr & 32'(BLK - 1), 0);
        chk("R1 mq_addr aligned", mq_addr & 32'(BLK - 1), 0);
        chk("R11 busy", 32'(busy), 32'(m_busy));
        chk("R10 bus_req", 32'(bus_req), 32'(m_cnt > 0));
        chk("R12 ident count", 32'(c_id), 32'(e_id[CW-1:0]));
        chk("R4 dup count", 32'(c_dup), 32'(e_dup[CW-1:0]));
        chk("R7 evict count", 32'(c_ev), 32'(e_ev[CW-1:0]));
        chk("R2 miss removal count", 32'(c_mr), 32'(e_mr[CW-1:0]));
        chk("R3 squash count", 32'(c_sq), 32'(e_sq[CW-1:0]));
        chk("R9 issue count", 32'(c_is), 32'(e_is[CW-1:0]));
        model_step();
        tnow = tnow + TW'(1);
    endtask

    task automatic idle();
        s_miss = 0; s_unc = 0; s_if = 0; s_cv = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        summary();
    end

    initial begin
        int seed_dummy;
        logic [CW-1:0] iss_saved;
        seed_dummy = $urandom(20240611);
        idle();
        s_rdy = 0;
        s_maddr = '0;
        for (int k = 0; k < DEGREE; k++) begin
            s_ca[k] = '0;
            s_cd[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R13: reset state
        chk("R13 reset pf_valid", 32'(pf_valid), 0);
        chk("R13 reset bus_req", 32'(bus_req), 0);
        chk("R13 reset busy", 32'(busy), 0);
        chk("R13 reset counters", 32'(c_id | c_dup | c_ev | c_mr | c_sq | c_is), 0);

        // R5: ignored misses leave a due entry in place
        s_cap = 1; s_sq = 0; s_do = 1;
        tick();
        s_miss = 1; s_maddr = 32'h80; s_cv = 3'b001; s_ca[0] = 32'h105; s_cd[0] = 8'd0;
        tick();
        idle();
        repeat (DEGREE) tick();
        s_miss = 1; s_maddr = 32'h104; s_unc = 1;
        tick();
        s_unc = 0; s_if = 1;
        tick();
        idle();
        tick();
        chk("R5 entry kept after ignored misses", 32'(pf_valid), 1);
        chk("R5 entry address", pf_addr, 32'h100);
        chk("R5 no miss removal", 32'(c_mr), 0);
        s_rdy = 1;
        tick();
        s_rdy = 0;

        // R6: at-issue cache check drains a cached block without issuing
        s_cap = 0; s_do = 0;
        s_miss = 1; s_maddr = 32'h40; s_cv = 3'b001; s_ca[0] = 32'hC0; s_cd[0] = 8'd5;
        tick();
        idle();
        repeat (DEGREE) tick();
        iss_saved = c_is;
        s_rdy = 1;
        repeat (6) tick();
        chk("R6 cached head popped", 32'(bus_req), 0);
        chk("R6 cached head not issued", 32'(c_is), 32'(iss_saved));

        // random phases over all mode combinations
        for (int ph = 0; ph < 8; ph++) begin
            s_cap = ph[0]; s_sq = ph[1]; s_do = ph[2];
            for (int c = 0; c < 400; c++) begin
                s_miss  = ($urandom % 4) == 0;
                s_maddr = AW'((($urandom % 24) << 6) | ($urandom % 64));
                s_unc   = ($urandom % 8) == 0;
                s_if    = ($urandom % 4) == 0;
                s_cv    = 3'($urandom % 8);
                for (int k = 0; k < DEGREE; k++) begin
                    s_ca[k] = AW'((($urandom % 24) << 6) | ($urandom % 64));
                    s_cd[k] = DW'($urandom % 16);
                end
                s_rdy = (c < 200) ? (($urandom % 8) == 0) : (($urandom % 3) != 0);
                tick();
            end
        end
        idle();
        s_rdy = 1;
        repeat (40) tick();
        summary();
    end
endmodule